// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control and status registers behind a simple word-addressed slave port that spans a 4 KB window (1024 word slots). Most writable registers are guarded by a lock flag. The flag is set after reset. Software must write a 16-bit magic value to a dedicated unlock slot before the guarded registers accept anything. A second magic value, written to the lock slot, closes the bank again. A key mismatch is silently ignored.

Every slot has a declared access direction. Some slots are write-only, such as the key slots. Some are read-only, such as the lock status, a PLL status word and a boot-mode word. Some are read/write. Slots outside the map are refused in both directions. A refused or locked-out access raises a one-cycle error flag and changes no state.

One register carries a one-bit security setting and stays writable while the bank is locked. Another is a reset-control word. An accepted write with bit 0 set to that word emits a one-cycle system reset request. A small group of general-purpose read/write registers completes the bank. Each of them has a distinct reset value.

Top module: `keyreg_bank`

## Requirements
- R1: After reset the registers hold these values:
  - lock status (word 0x003) reads 1;
  - PLL status (word 0x043) reads 0x0000003F;
  - boot mode (word 0x097) reads 0x00000001;
  - security (word 0x000) and reset control (word 0x080) read 0;
  - general register k (word 0x100+k, k = 0..7) reads 0xA5000000 + k.
- R2: The security register at word 0x000 stores only bit 0 of write data and reads back with bits 31:1 zero. It is writable whether the bank is locked or not.
- R3: A write to word 0x001 sets the lock when the low 16 data bits equal 0x767B, whatever the upper bits are. Any other value has no effect and raises no error.
- R4: A write to word 0x002 clears the lock when the low 16 data bits equal 0xDF0D. Any other value has no effect and raises no error.
- R5: While locked, a write to the reset-control word or to a general register is discarded and raises the error flag.
- R6: Access direction is enforced per slot:
  - words 0x001 and 0x002 are write-only; a read returns 0 with error;
  - words 0x003, 0x043 and 0x097 are read-only; a write raises the error flag and changes nothing.
- R7: Any word index outside the map is refused for both reads and writes: error set, read data 0, no state change.
- R8: An accepted write to word 0x080 stores all 32 bits. When data bit 0 is 1, `sys_rst_req` is high for exactly one cycle, the cycle after the write.
- R9: `rsp_rdata` and `rsp_err` are registered. Both are valid in the cycle after the request. `rsp_rdata` is 0 whenever no accepted read was issued in the previous cycle.
- R10: When `req_wr` and `req_rd` are both high, only the write is performed. The read is ignored and `rsp_rdata` is 0.
- R11: With the bank unlocked, each general register stores and returns full 32-bit values independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores all reset values |
| req_wr | input | 1 | Write request |
| req_rd | input | 1 | Read request |
| req_widx | input | 10 | Word index (byte offset divided by 4) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered one-cycle error for a refused access |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach from the ports is a guarded register changing state at all, because the bank leaves reset locked and only an exact key opens it. The stimulus first sweeps every slot in the 1024-word window while locked, with writes and reads. This shows that nothing but the security bit and the key slots react. It then offers near-miss keys and keys with noisy upper bits. Only after that does it unlock and sweep the whole window again. A bench-side model predicts every error flag, read value and reset pulse.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

  // Word indices whose position is fixed by behaviour of neighbouring software
  localparam int IDX_SEC     = 'h000;
  localparam int IDX_LOCK    = 'h001;
  localparam int IDX_UNLOCK  = 'h002;
  localparam int IDX_LSTAT   = 'h003;
  localparam int IDX_PLLSTAT = 'h043;
  localparam int IDX_RSTCTL  = 'h080;
  localparam int IDX_BOOT    = 'h097;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_LOCK   = 16'h767B;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'hDF0D;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_SEC,
    CLS_LOCK,
    CLS_UNLOCK,
    CLS_LSTAT,
    CLS_PLLSTAT,
    CLS_BOOT,
    CLS_RSTCTL,
    CLS_GP
  } reg_cls_e;

endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int WIDX_W   = 10,
  parameter int NUM_GP   = 8,
  parameter int GP_BASE  = 'h100,
  parameter int GP_IDX_W = 3
) (
  input  logic [WIDX_W-1:0]   widx,
  output reg_cls_e            cls,
  output logic [GP_IDX_W-1:0] gp_sel,
  output logic                rd_legal,
  output logic                wr_legal,
  output logic                gated
);

  logic [WIDX_W-1:0] gp_off;
  logic              in_gp;

  always_comb begin
    gp_off = widx - WIDX_W'(GP_BASE);
    gp_sel = gp_off[GP_IDX_W-1:0];
    in_gp  = (int'(widx) >= GP_BASE) && (int'(widx) < GP_BASE + NUM_GP);
    if (widx == WIDX_W'(IDX_SEC))           cls = CLS_SEC;
    else if (widx == WIDX_W'(IDX_LOCK))     cls = CLS_LOCK;
    else if (widx == WIDX_W'(IDX_UNLOCK))   cls = CLS_UNLOCK;
    else if (widx == WIDX_W'(IDX_LSTAT))    cls = CLS_LSTAT;
    else if (widx == WIDX_W'(IDX_PLLSTAT))  cls = CLS_PLLSTAT;
    else if (widx == WIDX_W'(IDX_RSTCTL))   cls = CLS_RSTCTL;
    else if (widx == WIDX_W'(IDX_BOOT))     cls = CLS_BOOT;
    else if (in_gp)                         cls = CLS_GP;
    else                                    cls = CLS_NONE;
  end

  always_comb begin
    rd_legal = 1'b0;
    wr_legal = 1'b0;
    gated    = 1'b0;
    unique case (cls)
      CLS_SEC:     begin rd_legal = 1'b1; wr_legal = 1'b1; end
      CLS_LOCK,
      CLS_UNLOCK:  wr_legal = 1'b1;
      CLS_LSTAT,
      CLS_PLLSTAT,
      CLS_BOOT:    rd_legal = 1'b1;
      CLS_RSTCTL,
      CLS_GP:      begin rd_legal = 1'b1; wr_legal = 1'b1; gated = 1'b1; end
      default:     ;
    endcase
  end

endmodule

// File: rtl/keyreg_lock.sv
module keyreg_lock
  import keyreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_wr,
  input  logic             unlock_wr,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  always_ff @(posedge clk) begin
    if (rst)                                locked <= 1'b1;
    else if (lock_wr && key == KEY_LOCK)    locked <= 1'b1;
    else if (unlock_wr && key == KEY_UNLOCK) locked <= 1'b0;
  end

  AST_LOCK_KEY_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !lock_wr && !unlock_wr) |-> $stable(locked)); // R3 R4

  AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(locked)) |-> $past(unlock_wr && key == KEY_UNLOCK)); // R4

endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
  import keyreg_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              NUM_GP     = 8,
  parameter int              GP_IDX_W   = 3,
  parameter logic [15:0]     GP_RST_TAG = 16'hA500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  reg_cls_e            cls,
  input  logic [GP_IDX_W-1:0] gp_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic                sec_q,
  output logic [DATA_W-1:0]   rstctl_q,
  output logic [DATA_W-1:0]   gp_rd
);

  logic [DATA_W-1:0] gp_q [NUM_GP];

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= 1'b0;
      rstctl_q <= '0;
    end else if (we) begin
      if (cls == CLS_SEC)    sec_q    <= wdata[0];
      if (cls == CLS_RSTCTL) rstctl_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (rst)
        gp_q[g] <= DATA_W'({GP_RST_TAG, 16'(g)});
      else if (we && cls == CLS_GP && gp_sel == GP_IDX_W'(g))
        gp_q[g] <= wdata;
    end
  end

  always_comb begin
    gp_rd = '0;
    for (int g = 0; g < NUM_GP; g++)
      if (gp_sel == GP_IDX_W'(g)) gp_rd = gp_q[g];
  end

  AST_RSTCTL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !we) |-> $stable(rstctl_q)); // R5

endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int          WIDX_W      = 10,
  parameter int          DATA_W      = 32,
  parameter int          NUM_GP      = 8,
  parameter int          GP_BASE     = 'h100,
  parameter logic [15:0] GP_RST_TAG  = 16'hA500,
  parameter logic [31:0] PLLSTAT_VAL = 32'h0000_003F,
  parameter logic [31:0] BOOT_VAL    = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [WIDX_W-1:0] req_widx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              sys_rst_req
);

  localparam int GP_IDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  reg_cls_e              cls;
  logic [GP_IDX_W-1:0]   gp_sel;
  logic                  rd_legal, wr_legal, gated;
  logic                  locked;
  logic                  wr_ok, rd_go;
  logic                  sec_q;
  logic [DATA_W-1:0]     rstctl_q, gp_rd, rd_val;

  keyreg_decode #(
    .WIDX_W(WIDX_W), .NUM_GP(NUM_GP), .GP_BASE(GP_BASE), .GP_IDX_W(GP_IDX_W)
  ) u_decode (
    .widx(req_widx), .cls(cls), .gp_sel(gp_sel),
    .rd_legal(rd_legal), .wr_legal(wr_legal), .gated(gated)
  );

  assign wr_ok = req_wr && wr_legal && !(gated && locked);
  assign rd_go = req_rd && !req_wr;

  keyreg_lock u_lock (
    .clk(clk), .rst(rst),
    .lock_wr(wr_ok && cls == CLS_LOCK),
    .unlock_wr(wr_ok && cls == CLS_UNLOCK),
    .key(req_wdata[KEY_W-1:0]),
    .locked(locked)
  );

  keyreg_store #(
    .DATA_W(DATA_W), .NUM_GP(NUM_GP), .GP_IDX_W(GP_IDX_W), .GP_RST_TAG(GP_RST_TAG)
  ) u_store (
    .clk(clk), .rst(rst), .we(wr_ok), .cls(cls), .gp_sel(gp_sel),
    .wdata(req_wdata), .sec_q(sec_q), .rstctl_q(rstctl_q), .gp_rd(gp_rd)
  );

  always_comb begin
    unique case (cls)
      CLS_SEC:     rd_val = {{(DATA_W-1){1'b0}}, sec_q};
      CLS_LSTAT:   rd_val = {{(DATA_W-1){1'b0}}, locked};
      CLS_PLLSTAT: rd_val = DATA_W'(PLLSTAT_VAL);
      CLS_BOOT:    rd_val = DATA_W'(BOOT_VAL);
      CLS_RSTCTL:  rd_val = rstctl_q;
      CLS_GP:      rd_val = gp_rd;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      rsp_rdata   <= (rd_go && rd_legal) ? rd_val : '0;
      rsp_err     <= (req_wr && !wr_ok) || (rd_go && !rd_legal);
      sys_rst_req <= wr_ok && cls == CLS_RSTCTL && req_wdata[0];
    end
  end

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0); // R7

  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_wr) |-> rsp_rdata == '0); // R10

  AST_LOCKED_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && locked && req_wr && gated) |-> rsp_err); // R5

  AST_RST_REQ_SRC: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(req_wr && !locked && req_widx == WIDX_W'(IDX_RSTCTL) && req_wdata[0])); // R8

endmodule

// File: tb/keyreg_bank_bench.sv
module keyreg_bank_bench;

  localparam int NW = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_wr, req_rd;
  logic [9:0]  req_widx;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        sys_rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m [NW];
  logic        mlock;

  always #10 clk = ~clk;

  keyreg_bank u_keyreg_bank (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .req_widx(req_widx), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sys_rst_req(sys_rst_req)
  );

  function automatic bit is_gp(int i);
    return i >= 'h100 && i < 'h108;
  endfunction
  function automatic bit can_rd(int i);
    return i == 0 || i == 3 || i == 'h43 || i == 'h80 || i == 'h97 || is_gp(i);
  endfunction
  function automatic bit can_wr(int i);
    return i == 0 || i == 1 || i == 2 || i == 'h80 || is_gp(i);
  endfunction
  function automatic bit guarded(int i);
    return i == 'h80 || is_gp(i);
  endfunction
  function automatic logic [31:0] pat(int i, logic [31:0] salt);
    return (32'h5A00_0001 ^ (32'(i) << 8)) ^ salt;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) m[i] = '0;
    m['h43] = 32'h3F;
    m['h97] = 32'h1;
    for (int k = 0; k < 8; k++) m['h100 + k] = 32'hA500_0000 + 32'(k);
    mlock = 1'b1;
  endtask

  task automatic do_write(int i, logic [31:0] d, string tag);
    bit ex_err, ex_pulse;
    ex_pulse = 1'b0;
    if (!can_wr(i) || (guarded(i) && mlock)) ex_err = 1'b1;
    else begin
      ex_err = 1'b0;
      if (i == 0) m[0] = {31'b0, d[0]};
      else if (i == 1) begin if (d[15:0] == 16'h767B) mlock = 1'b1; end
      else if (i == 2) begin if (d[15:0] == 16'hDF0D) mlock = 1'b0; end
      else m[i] = d;
      ex_pulse = (i == 'h80) && d[0];
    end
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b0; req_widx = 10'(i); req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    chk(rsp_err == ex_err, {tag, " wr err"}, 32'(rsp_err), 32'(ex_err));
    chk(sys_rst_req == ex_pulse, {tag, " R8 pulse"}, 32'(sys_rst_req), 32'(ex_pulse));
  endtask

  task automatic do_read(int i, string tag);
    logic [31:0] ex;
    ex = !can_rd(i) ? 32'h0 : (i == 3) ? {31'b0, mlock} : m[i];
    @(negedge clk);
    req_rd = 1'b1; req_wr = 1'b0; req_widx = 10'(i);
    @(negedge clk);
    req_rd = 1'b0;
    chk(rsp_rdata == ex, {tag, " rd data"}, rsp_rdata, ex);
    chk(rsp_err == !can_rd(i), {tag, " rd err"}, 32'(rsp_err), 32'(!can_rd(i)));
    chk(sys_rst_req == 1'b0, {tag, " R8 no pulse on read"}, 32'(sys_rst_req), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_wr = 1'b0; req_rd = 1'b0; req_widx = '0; req_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_rdata == 0 && rsp_err == 0 && sys_rst_req == 0, "R1 idle outputs",
        {rsp_rdata[29:0], rsp_err, sys_rst_req}, 32'h0);

    // R1 R6 R7 R9: reset values and read legality across the whole window
    for (int i = 0; i < NW; i++) do_read(i, "R1/R6/R7/R9 reset sweep");

    // R5 R6 R7: locked write sweep; R2 security stays writable while locked
    for (int i = 0; i < NW; i++) do_write(i, pat(i, 32'h0), "R5/R6/R7 locked sweep");
    for (int i = 0; i < NW; i++) do_read(i, "R5/R2 after locked sweep");

    // R2: only bit 0 kept, writable while locked
    do_write(0, 32'hFFFF_FFFE, "R2 sec clear");
    do_read(0, "R2 sec reads 0");
    do_write(0, 32'h8000_0003, "R2 sec set");
    do_read(0, "R2 sec bit0 only");

    // R4: near-miss unlock keys are ignored without error
    do_write(2, 32'h0000_DF0C, "R4 wrong key");
    do_write(2, 32'hDF0D_0000, "R4 key in high half");
    do_read(3, "R4 still locked");
    do_write('h101, 32'h1234_5678, "R5 still guarded");
    do_read('h101, "R5 unchanged");
    do_write(2, 32'hABCD_DF0D, "R4 unlock with noisy upper bits");
    do_read(3, "R4 unlocked status");

    // R11 R8 R6 R7: unlocked sweep
    for (int i = 0; i < NW; i++) do_write(i, pat(i, 32'h00C3_0000), "R11/R8/R6/R7 unlocked sweep");
    for (int i = 0; i < NW; i++) do_read(i, "R11/R6 after unlocked sweep");

    // R8: pulse lasts one cycle, value stored, bit0 clear gives no pulse
    do_write('h80, 32'hF00D_0001, "R8 soft reset");
    @(negedge clk);
    chk(sys_rst_req == 1'b0, "R8 pulse one cycle", 32'(sys_rst_req), 32'h0);
    do_read('h80, "R8 stored value");
    do_write('h80, 32'hF00D_0002, "R8 bit0 clear");
    do_read('h80, "R8 stored value 2");

    // R10: simultaneous write and read
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1; req_widx = 10'h104; req_wdata = 32'h0BAD_CAFE;
    m['h104] = 32'h0BAD_CAFE;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0;
    chk(rsp_rdata == 32'h0, "R10 read ignored", rsp_rdata, 32'h0);
    chk(rsp_err == 1'b0, "R10 no error", 32'(rsp_err), 32'h0);
    do_read('h104, "R10 write performed");

    // R3: relock with noisy upper bits, wrong key ignored
    do_write(1, 32'h0000_767C, "R3 wrong key");
    do_read(3, "R3 still unlocked");
    do_write(1, 32'h1111_767B, "R3 lock");
    do_read(3, "R3 locked status");
    do_write('h80, 32'h1, "R3/R5 guarded again");
    do_read('h80, "R5 rstctl kept");

    // R1: external reset restores reset values
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    for (int i = 0; i < 'h110; i++) do_read(i, "R1 after second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule